// File: doc/BRIEF.md
# Power-to-Frequency Pulse Generator

This block turns a stream of signed, already low-pass-filtered real-power samples into pulse trains whose rate follows the average power. Each valid sample adds its magnitude to two accumulators. When an accumulator reaches its threshold, the block emits a pulse and subtracts the threshold, so the remainder carries forward. The averaging therefore comes from the accumulation itself and needs no separate filter.

There are two kinds of output. The first is a pair of slow, active-low pulse lines whose full-scale rate is a binary fraction of the clock, set by a two-bit rate code. They fire in turn and never overlap. The second is a fast calibration line that pulses at a power-of-two multiple of the slow rate, set by a scale bit. A reverse-flow flag, with hysteresis, reports the sign of the power so that external counters can choose their counting direction.

Top module: `pwr_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears both accumulators. After that edge `slow_a_n` and `slow_b_n` are 1, `fast_o` is 0 and `rev_o` is 0.
- R2: The slow threshold is 2^(FS_DIV_EXP+SAMPLE_W-1-c), where c is the active rate code. A full-scale magnitude of 2^(SAMPLE_W-1) on every cycle therefore gives slow pulses at clock/2^(FS_DIV_EXP-c), which for FS_DIV_EXP=21 is clock/2^21, 2^20, 2^19 and 2^18 for `fsel` = 00, 01, 10 and 11.
- R3: Slow crossings drive `slow_a_n` and `slow_b_n` in strict turn, starting with `slow_a_n` after reset. The two lines are never low in the same cycle.
- R4: A slow crossing at a clock edge drives the chosen line low after that edge. The line stays low for exactly PULSE_LEN cycles.
- R5: With the active scale bit at 0, the fast threshold is the slow threshold divided by 2^FAST_MUL0_EXP (default 2048). This gives 2048 fast pulses per slow pulse.
- R6: With the active scale bit at 1, the fast threshold is the slow threshold divided by 2^FAST_MUL1_EXP (default 128).
- R7: A change on `fsel` or `fast_scale` takes effect only after the next slow crossing. The values present at that crossing edge, and the values at reset, become active.
- R8: On a crossing the block subtracts only the threshold. The remainder, including the remainder left when the rate code changes, carries into the next interval.
- R9: A sample counts by its magnitude in two's complement. A negative sample adds the same amount as its positive counterpart, and the most negative value adds 2^(SAMPLE_W-1).
- R10: `rev_o` sets after a valid sample below -REV_HYST and clears after a valid sample above +REV_HYST. Valid samples within ±REV_HYST leave it unchanged.
- R11: A cycle with `smp_vld` low adds nothing to either accumulator and leaves `rev_o` unchanged. No pulse starts after that cycle's edge.
- R12: A fast crossing at a clock edge makes `fast_o` high for the one cycle after that edge. At most one fast pulse is produced per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp | input | SAMPLE_W | Signed filtered real-power sample |
| smp_vld | input | 1 | Sample valid strobe |
| fsel | input | 2 | Slow rate code |
| fast_scale | input | 1 | Fast multiple select |
| slow_a_n | output | 1 | First slow pulse line, active low |
| slow_b_n | output | 1 | Second slow pulse line, active low |
| fast_o | output | 1 | Fast calibration pulse, active high |
| rev_o | output | 1 | Reverse power flow flag |

## Verification
Several properties are checked on every cycle. The slow lines never overlap, and every slow low interval lasts exactly PULSE_LEN cycles. No pulse and no flag change follow a cycle without a valid sample, and the reverse flag sets or holds as the hysteresis band requires. Other behaviour is visible only over long runs, and the bench's scenarios are needed for it. That behaviour covers the absolute rates for each rate code, the 2048× and 128× fast ratios, the deferred take-up of a new rate code and the carried remainder. The bench's cycle-level model also compares every output on every clock.

// File: rtl/p2f_pkg.sv
package p2f_pkg;
  typedef enum logic {TURN_A = 1'b0, TURN_B = 1'b1} slow_turn_e;

  // exponent of the slow threshold for a given rate code
  function automatic int slow_shift(input int top_exp, input logic [1:0] code);
    return top_exp - int'(code);
  endfunction
endpackage

// File: rtl/p2f_accum.sv
module p2f_accum #(
  parameter int MAG_W = 16,
  parameter int ACC_W = 37
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic [MAG_W-1:0] add_val,
  input  logic [ACC_W-1:0] thresh,
  output logic             hit
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum = acc_q + ACC_W'(add_val);
  assign hit = add_en && (sum >= thresh);

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (add_en)
      acc_q <= hit ? (sum - thresh) : sum;
  end
endmodule

// File: rtl/p2f_slow_drv.sv
module p2f_slow_drv import p2f_pkg::*; #(
  parameter int PULSE_LEN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic line_a_n,
  output logic line_b_n
);
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] left_q;
  slow_turn_e    turn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_a_n <= 1'b1;
      line_b_n <= 1'b1;
      left_q   <= '0;
      turn_q   <= TURN_A;
    end else if (fire) begin
      left_q <= CW'(PULSE_LEN);
      if (turn_q == TURN_A) begin
        line_a_n <= 1'b0;
        turn_q   <= TURN_B;
      end else begin
        line_b_n <= 1'b0;
        turn_q   <= TURN_A;
      end
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
      if (left_q == CW'(1)) begin
        line_a_n <= 1'b1;
        line_b_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/p2f_rev_det.sv
module p2f_rev_det #(
  parameter int SAMPLE_W = 16,
  parameter int REV_HYST = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic                       smp_vld,
  output logic                       rev_o
);
  localparam logic signed [SAMPLE_W-1:0] BAND_HI = SAMPLE_W'(REV_HYST);
  localparam logic signed [SAMPLE_W-1:0] BAND_LO = -BAND_HI;

  always_ff @(posedge clk) begin
    if (rst)
      rev_o <= 1'b0;
    else if (smp_vld) begin
      if (smp < BAND_LO)
        rev_o <= 1'b1;
      else if (smp > BAND_HI)
        rev_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_pulse_gen.sv
module pwr_pulse_gen import p2f_pkg::*; #(
  parameter int SAMPLE_W      = 16,
  parameter int FS_DIV_EXP    = 21,
  parameter int FAST_MUL0_EXP = 11,
  parameter int FAST_MUL1_EXP = 7,
  parameter int PULSE_LEN     = 64,
  parameter int REV_HYST      = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic                       smp_vld,
  input  logic [1:0]                 fsel,
  input  logic                       fast_scale,
  output logic                       slow_a_n,
  output logic                       slow_b_n,
  output logic                       fast_o,
  output logic                       rev_o
);
  localparam int THR_EXP = FS_DIV_EXP + SAMPLE_W - 1;
  localparam int ACC_W   = THR_EXP + 1;
  localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

  logic [SAMPLE_W-1:0] mag;
  logic [1:0]          sel_act;
  logic                scale_act;
  logic [ACC_W-1:0]    thr   [2];
  logic [1:0]          hit;

  // magnitude; the most negative code maps to 2^(SAMPLE_W-1)
  assign mag = smp[SAMPLE_W-1] ? $unsigned(-smp) : $unsigned(smp);

  // thresholds: path 0 slow, path 1 fast
  always_comb begin
    thr[0] = ONE << slow_shift(THR_EXP, sel_act);
    thr[1] = thr[0] >> (scale_act ? FAST_MUL1_EXP : FAST_MUL0_EXP);
  end

  for (genvar g = 0; g < 2; g++) begin : g_path
    p2f_accum #(.MAG_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .add_en  (smp_vld),
      .add_val (mag),
      .thresh  (thr[g]),
      .hit     (hit[g])
    );
  end

  // rate code and scale are taken up only at a slow crossing
  always_ff @(posedge clk) begin
    if (rst || hit[0]) begin
      sel_act   <= fsel;
      scale_act <= fast_scale;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      fast_o <= 1'b0;
    else
      fast_o <= hit[1];
  end

  p2f_slow_drv #(.PULSE_LEN(PULSE_LEN)) u_slow (
    .clk      (clk),
    .rst      (rst),
    .fire     (hit[0]),
    .line_a_n (slow_a_n),
    .line_b_n (slow_b_n)
  );

  p2f_rev_det #(.SAMPLE_W(SAMPLE_W), .REV_HYST(REV_HYST)) u_rev (
    .clk     (clk),
    .rst     (rst),
    .smp     (smp),
    .smp_vld (smp_vld),
    .rev_o   (rev_o)
  );
endmodule

// File: rtl/p2f_checker.sv
module p2f_checker #(
  parameter int SAMPLE_W  = 16,
  parameter int PULSE_LEN = 64,
  parameter int REV_HYST  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic signed [SAMPLE_W-1:0] smp,
  input logic                       smp_vld,
  input logic                       slow_a_n,
  input logic                       slow_b_n,
  input logic                       fast_o,
  input logic                       rev_o
);
  localparam int LW = $clog2(PULSE_LEN + 2) + 1;
  localparam logic [LW-1:0] LMAX = {LW{1'b1}};
  localparam logic signed [SAMPLE_W-1:0] BAND_HI = SAMPLE_W'(REV_HYST);
  localparam logic signed [SAMPLE_W-1:0] BAND_LO = -BAND_HI;

  logic [LW-1:0] low_a, low_b;

  always_ff @(posedge clk) begin
    if (rst || slow_a_n) low_a <= '0;
    else if (low_a != LMAX) low_a <= low_a + 1'b1;
    if (rst || slow_b_n) low_b <= '0;
    else if (low_b != LMAX) low_b <= low_b + 1'b1;
  end

  AST_SLOW_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!slow_a_n && !slow_b_n)); // R3
  AST_WIDTH_A_EXACT: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_a_n) |-> low_a == LW'(PULSE_LEN)); // R4
  AST_WIDTH_B_EXACT: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_b_n) |-> low_b == LW'(PULSE_LEN)); // R4
  AST_WIDTH_BOUND: assert property (@(posedge clk) disable iff (rst)
    (low_a <= LW'(PULSE_LEN)) && (low_b <= LW'(PULSE_LEN))); // R4
  AST_IDLE_NO_FAST: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !fast_o); // R11
  AST_IDLE_NO_SLOW: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !$fell(slow_a_n) && !$fell(slow_b_n)); // R11
  AST_IDLE_REV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> $stable(rev_o)); // R11
  AST_REV_SET: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp < BAND_LO) |=> rev_o); // R10
  AST_REV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp > BAND_HI) |=> !rev_o); // R10
  AST_REV_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && smp >= BAND_LO && smp <= BAND_HI) |=> $stable(rev_o)); // R10
endmodule

bind pwr_pulse_gen p2f_checker #(
  .SAMPLE_W  (SAMPLE_W),
  .PULSE_LEN (PULSE_LEN),
  .REV_HYST  (REV_HYST)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp      (smp),
  .smp_vld  (smp_vld),
  .slow_a_n (slow_a_n),
  .slow_b_n (slow_b_n),
  .fast_o   (fast_o),
  .rev_o    (rev_o)
);

// File: tb/tb_pwr_pulse_gen.sv
`timescale 1ns/1ps
module tb_pwr_pulse_gen;
  localparam int W    = 8;
  localparam int FSX  = 14;
  localparam int FM0  = 11;
  localparam int FM1  = 7;
  localparam int PLEN = 8;
  localparam int HYS  = 4;
  localparam int TEXP = FSX + W - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [W-1:0] smp = '0;
  logic smp_vld = 1'b0;
  logic [1:0] fsel = 2'b00;
  logic fast_scale = 1'b0;
  logic slow_a_n, slow_b_n, fast_o, rev_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_pulse_gen #(.SAMPLE_W(W), .FS_DIV_EXP(FSX), .FAST_MUL0_EXP(FM0),
    .FAST_MUL1_EXP(FM1), .PULSE_LEN(PLEN), .REV_HYST(HYS)) dut (
    .clk(clk), .rst(rst), .smp(smp), .smp_vld(smp_vld), .fsel(fsel),
    .fast_scale(fast_scale), .slow_a_n(slow_a_n), .slow_b_n(slow_b_n),
    .fast_o(fast_o), .rev_o(rev_o));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint m_acc_s, m_acc_f;
  int m_sel, m_scl, m_turn, m_left;
  bit e_a = 1, e_b = 1, e_f = 0, e_rev = 0, started = 0;

  always @(posedge clk) begin
    longint thr_s, thr_f;
    int s, mag;
    if (rst) begin
      m_acc_s = 0; m_acc_f = 0; m_sel = fsel; m_scl = fast_scale;
      m_turn = 0; m_left = 0; e_a = 1; e_b = 1; e_f = 0; e_rev = 0;
      started = 1;
    end else begin
      bit s_hit, f_hit;
      thr_s = longint'(1) << (TEXP - m_sel);
      thr_f = thr_s >> (m_scl ? FM1 : FM0);
      s_hit = 0; f_hit = 0;
      s = smp;
      mag = (s < 0) ? -s : s;
      if (smp_vld) begin
        m_acc_s += mag;
        if (m_acc_s >= thr_s) begin m_acc_s -= thr_s; s_hit = 1; end
        m_acc_f += mag;
        if (m_acc_f >= thr_f) begin m_acc_f -= thr_f; f_hit = 1; end
        if (s < -HYS) e_rev = 1;
        else if (s > HYS) e_rev = 0;
      end
      e_f = f_hit;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin e_a = 1; e_b = 1; end
      end
      if (s_hit) begin
        if (m_turn == 0) e_a = 0; else e_b = 0;
        m_turn ^= 1;
        m_left = PLEN;
        m_sel = fsel;
        m_scl = fast_scale;
      end
    end
  end

  // per-cycle comparison and pulse counters
  longint n_a = 0, n_b = 0, n_f = 0, low_a = 0;
  bit prev_a = 1, prev_b = 1;
  always @(negedge clk) begin
    if (started && !done) begin
      check(slow_a_n === e_a, "R4 slow_a_n", slow_a_n, e_a);
      check(slow_b_n === e_b, "R3 slow_b_n", slow_b_n, e_b);
      check(fast_o === e_f, "R12 fast_o", fast_o, e_f);
      check(rev_o === e_rev, "R10 rev_o", rev_o, e_rev);
    end
    if (prev_a && !slow_a_n) n_a++;
    if (prev_b && !slow_b_n) n_b++;
    if (fast_o) n_f++;
    if (!slow_a_n) low_a++;
    prev_a = slow_a_n;
    prev_b = slow_b_n;
  end

  // every task starts and ends 2 ns after a rising edge
  task automatic drive(input int s, input bit v, input int n);
    smp = W'(s);
    smp_vld = v;
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input int code, input bit scl);
    rst = 1; smp_vld = 0; fsel = code[1:0]; fast_scale = scl;
    repeat (2) @(posedge clk);
    #2;
    rst = 0;
  endtask

  longint sa, sb, sf, sl;
  task automatic snap();
    sa = n_a; sb = n_b; sf = n_f; sl = low_a;
  endtask

  initial begin
    @(posedge clk); #2;
    do_reset(0, 0);
    // R1 reset state
    check(slow_a_n === 1'b1, "R1 slow_a_n", slow_a_n, 1);
    check(slow_b_n === 1'b1, "R1 slow_b_n", slow_b_n, 1);
    check(fast_o === 1'b0, "R1 fast_o", fast_o, 0);
    check(rev_o === 1'b0, "R1 rev_o", rev_o, 0);

    // R2/R9: code 00, most negative sample, one slow pulse per 16384 cycles
    snap();
    drive(-128, 1, 32768);
    drive(0, 0, 12);
    check(n_a + n_b - sa - sb == 2, "R2 slow count code00", n_a + n_b - sa - sb, 2);
    check(n_a - sa == 1 && n_b - sb == 1, "R3 alternation", n_a - sa, 1);
    check(rev_o === 1'b1, "R9 negative full scale sets rev", rev_o, 1);

    // R5: code 11, scale 0 -> 2048 fast per slow
    do_reset(3, 0);
    snap();
    drive(-128, 1, 8192);
    drive(0, 0, 12);
    check(n_a + n_b - sa - sb == 4, "R2 slow count code11", n_a + n_b - sa - sb, 4);
    check(n_f - sf == 2048 * (n_a + n_b - sa - sb), "R5 fast ratio 2048", n_f - sf, 8192);
    check(low_a - sl == PLEN * (n_a - sa), "R4 low width", low_a - sl, PLEN * (n_a - sa));

    // R6: scale 1 -> 128 fast per slow
    do_reset(3, 1);
    snap();
    drive(64, 1, 8192);
    drive(0, 0, 12);
    check(n_a + n_b - sa - sb == 2, "R6 slow count", n_a + n_b - sa - sb, 2);
    check(n_f - sf == 256, "R6 fast ratio 128", n_f - sf, 256);
    check(rev_o === 1'b0, "R10 positive keeps rev clear", rev_o, 0);

    // R7: new code waits for the next slow crossing
    do_reset(0, 0);
    snap();
    drive(-128, 1, 1000);
    fsel = 2'b11;
    drive(-128, 1, 15384 + 2048);
    drive(0, 0, 12);
    check(n_a + n_b - sa - sb == 2, "R7 deferred code change", n_a + n_b - sa - sb, 2);

    // R8: remainder carried: 100 per cycle against 2^18
    do_reset(3, 0);
    snap();
    drive(100, 1, 5243);
    drive(0, 0, 12);
    check(n_a + n_b - sa - sb == 2, "R8 remainder carried", n_a + n_b - sa - sb, 2);

    // R11: invalid samples ignored
    snap();
    drive(-128, 0, 5000);
    drive(0, 0, 4);
    check(n_a + n_b - sa - sb == 0, "R11 no slow pulse", n_a + n_b - sa - sb, 0);
    check(n_f - sf == 0, "R11 no fast pulse", n_f - sf, 0);
    check(rev_o === 1'b0, "R11 rev unchanged", rev_o, 0);

    // R10 hysteresis
    do_reset(0, 0);
    drive(-3, 1, 3);
    check(rev_o === 1'b0, "R10 inside band", rev_o, 0);
    drive(-5, 1, 1);
    check(rev_o === 1'b1, "R10 set below band", rev_o, 1);
    drive(3, 1, 3);
    check(rev_o === 1'b1, "R10 hold inside band", rev_o, 1);
    drive(-128, 0, 2);
    drive(5, 0, 2);
    check(rev_o === 1'b1, "R11 invalid positive ignored", rev_o, 1);
    drive(5, 1, 1);
    check(rev_o === 1'b0, "R10 clear above band", rev_o, 0);
    // R12: fast pulse follows the crossing edge for one cycle
    drive(0, 0, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule